// File: doc/BRIEF.md
# Two-Wire Converter Readout Port

This block is the device side of a read-only serial port with two wires, placed between a converter core and a host. The host drives a serial clock. The block answers on one combined line that carries both the ready flag and the data. The line rests high. It drops low when the core delivers a fresh result word. Each rising serial clock edge after that puts the next result bit on the line, most significant bit first, in two's complement.

There is no select pin and there are no command bytes. The block works out every request from two things: how many rising edges arrive after the ready indication, and how long the clock stays high. A 25th edge releases the line high. A complete 26th pulse asks the core to self-calibrate. A clock held high for a programmable number of system cycles puts the core to sleep. Releasing the clock wakes the core, with a calibration first if the hold began on the 26th pulse. The serial clock is brought into the system clock domain through two flops. Its rate must stay below a quarter of the system clock rate, and its high phase must be shorter than `HOLD_CYC` system cycles. `HOLD_CYC` must be at least 8.

Top module: `adc_2w_port`

## Requirements
- R1: After reset the line is high. A result taken while no data is pending drives the line low at the next clock edge.
- R2: Each synchronised rising serial clock edge numbered 1 to 24 puts result bit 24−n on the line, where n is the edge number. Bit 23 goes first.
- R3: After the 24th edge, the line keeps the value of bit 0 for as long as no further edge arrives.
- R4: The 25th rising edge drives the line high.
- R5: The falling edge that ends the 26th pulse gives a one-cycle `cal_req`. The line then stays high until the core delivers the next result.
- R6: If the serial clock stays high for `HOLD_CYC` system cycles while a result is pending, at any bit count, the block gives a one-cycle `sleep_req` and drives the line high. A high phase shorter than that never gives `sleep_req`.
- R7: A falling serial clock edge during sleep gives a one-cycle `wake_req`, and the line stays high until the next result. A result strobe during sleep is ignored.
- R8: A sleep entered from the 26th pulse raises `wake_req` and `cal_req` in the same cycle on release. No `cal_req` is given at sleep entry.
- R9: A result that arrives while the previous one is unread replaces it. The following read returns the newer word.
- R10: A result that arrives after 1 to 23 bits have been shifted is discarded. The read in progress carries on with the old word.
- R11: A result that arrives after the 24th or the 25th edge is accepted. The line drops low and the bit count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| conv_done | input | 1 | One-cycle strobe from the core: a new result is valid |
| conv_word | input | WORD_W | Result word, two's complement |
| rdy_dout | output | 1 | Combined ready/data line |
| cal_req | output | 1 | One-cycle request for a self-calibration |
| sleep_req | output | 1 | One-cycle request to enter sleep |
| wake_req | output | 1 | One-cycle request to wake and restart conversion |

## Verification
A serial clock edge at the pin passes through two synchroniser flops and one output register. The line therefore changes three system clock edges after the edge, and the bench samples it five cycles after each rise, inside a six-cycle high phase. A result strobe shows on the line one edge after it is taken, so the bench looks one cycle after the strobe is dropped. Request strobes are counted on falling clock edges. The bench compares those counts a few cycles after each serial clock release, and `HOLD_CYC` plus ten cycles after the start of a long high hold.

// File: rtl/adc_2w_port.sv
module adc_2w_port #(
  parameter int WORD_W   = 24,
  parameter int HOLD_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              conv_done,
  input  logic [WORD_W-1:0] conv_word,
  output logic              rdy_dout,
  output logic              cal_req,
  output logic              sleep_req,
  output logic              wake_req
);

  localparam int CW = $clog2(WORD_W + 3);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] N_LAST = CW'(WORD_W);
  localparam logic [CW-1:0] N_REL  = CW'(WORD_W + 1);
  localparam logic [CW-1:0] N_CAL  = CW'(WORD_W + 2);
  localparam logic [HW-1:0] HI_TOP = HW'(HOLD_CYC - 1);
  localparam logic [1:0] ST_WAIT  = 2'd0;
  localparam logic [1:0] ST_DATA  = 2'd1;
  localparam logic [1:0] ST_SLEEP = 2'd2;

  logic [2:0]        sy;
  logic [1:0]        st;
  logic [CW-1:0]     cnt;
  logic [HW-1:0]     hi_cnt;
  logic [WORD_W-1:0] sh;
  logic              cal_wake;

  wire s_hi    = sy[1];
  wire rise    = sy[1] & ~sy[2];
  wire fall    = ~sy[1] & sy[2];
  wire in_data = (st == ST_DATA);
  wire long_hi = in_data && s_hi && (hi_cnt == HI_TOP);
  wire take    = conv_done && (cnt == '0 || cnt == N_LAST || cnt == N_REL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sy <= '0;
    else        sy <= {sy[1:0], sclk};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      hi_cnt <= '0;
    else if (!in_data || !s_hi)      hi_cnt <= '0;
    else if (hi_cnt != HI_TOP)       hi_cnt <= hi_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_WAIT;
      cnt       <= '0;
      sh        <= '0;
      rdy_dout  <= 1'b1;
      cal_req   <= 1'b0;
      sleep_req <= 1'b0;
      wake_req  <= 1'b0;
      cal_wake  <= 1'b0;
    end else begin
      cal_req   <= 1'b0;
      sleep_req <= 1'b0;
      wake_req  <= 1'b0;
      case (st)
        ST_WAIT: begin
          if (conv_done) begin
            sh       <= conv_word;
            rdy_dout <= 1'b0;
            cnt      <= '0;
            st       <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (long_hi) begin
            st        <= ST_SLEEP;
            rdy_dout  <= 1'b1;
            sleep_req <= 1'b1;
            cal_wake  <= (cnt == N_CAL);
          end else if (take) begin
            sh       <= conv_word;
            rdy_dout <= 1'b0;
            cnt      <= '0;
          end else if (rise) begin
            if (cnt < N_LAST) begin
              rdy_dout <= sh[WORD_W-1];
              sh       <= {sh[WORD_W-2:0], 1'b0};
              cnt      <= cnt + 1'b1;
            end else if (cnt == N_LAST) begin
              rdy_dout <= 1'b1;
              cnt      <= cnt + 1'b1;
            end else if (cnt == N_REL) begin
              cnt <= cnt + 1'b1;
            end
          end else if (fall && cnt == N_CAL) begin
            cal_req  <= 1'b1;
            rdy_dout <= 1'b1;
            st       <= ST_WAIT;
          end
        end
        default: begin
          if (fall) begin
            wake_req <= 1'b1;
            cal_req  <= cal_wake;
            st       <= ST_WAIT;
          end
        end
      endcase
    end
  end

endmodule

module adc_2w_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sclk,
  input logic       conv_done,
  input logic       rdy_dout,
  input logic       cal_req,
  input logic       sleep_req,
  input logic       wake_req,
  input logic [1:0] st
);

  p_accept_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && conv_done) |=> !rdy_dout);

  p_cal_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cal_req |-> rdy_dout);

  p_sleep_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> rdy_dout);

  p_sleep_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> $past(sclk, 3));

  p_wake_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> rdy_dout);

  p_sleep_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2) |-> rdy_dout);

  p_no_cal_on_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> (!cal_req && !wake_req));

endmodule

bind adc_2w_port adc_2w_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .conv_done(conv_done),
  .rdy_dout(rdy_dout), .cal_req(cal_req), .sleep_req(sleep_req),
  .wake_req(wake_req), .st(st)
);

// File: tb/test_adc_2w_port.sv
module test_adc_2w_port;
  localparam int W = 24;
  localparam int HOLD = 32;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, conv_done = 1'b0;
  logic [W-1:0] conv_word = '0;
  logic rdy_dout, cal_req, sleep_req, wake_req;
  int total = 0, bad = 0;
  int n_cal = 0, n_sleep = 0, n_wake = 0;

  always #5 clk = ~clk;

  adc_2w_port #(.WORD_W(W), .HOLD_CYC(HOLD)) i_adc_2w_port (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .conv_done(conv_done),
    .conv_word(conv_word), .rdy_dout(rdy_dout), .cal_req(cal_req),
    .sleep_req(sleep_req), .wake_req(wake_req)
  );

  always @(negedge clk) begin
    if (cal_req)   n_cal++;
    if (sleep_req) n_sleep++;
    if (wake_req)  n_wake++;
  end

  function automatic logic exp_bit(logic [W-1:0] w, int idx);
    return w[W-1-idx];
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic deliver(input logic [W-1:0] w);
    @(negedge clk);
    conv_done = 1'b1;
    conv_word = w;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic pulse(output logic b);
    @(negedge clk);
    sclk = 1'b1;
    idle(5);
    b = rdy_dout;
    idle(1);
    sclk = 1'b0;
    idle(6);
  endtask

  task automatic read_bits(input int from, input int upto, input logic [W-1:0] w,
                           input string req, output int errs);
    logic b;
    errs = 0;
    for (int i = from; i < upto; i++) begin
      pulse(b);
      if (b !== exp_bit(w, i)) errs++;
    end
    check(req, errs, 0);
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] a, b2, c;
    logic bt;
    int e, s0, c0, w0;
    void'($urandom(32'h5eed_1234));
    idle(3);
    check("R1 reset line", rdy_dout, 1);
    rst_n = 1'b1;
    idle(3);
    check("R1 idle line", rdy_dout, 1);

    a = 24'hA5_3C_81;
    deliver(a);
    check("R1 ready low", rdy_dout, 0);
    read_bits(0, W, a, "R2 directed word", e);
    idle(20);
    check("R3 holds last bit", rdy_dout, a[0]);
    pulse(bt);
    check("R4 25th edge high", bt, 1);

    for (int k = 0; k < 20; k++) begin
      c = W'($urandom);
      if (k == 0) c = 24'h80_0000;
      if (k == 1) c = 24'h7F_FFFF;
      deliver(c);
      check("R11 accepted after read", rdy_dout, 0);
      read_bits(0, W, c, "R2 random word", e);
      if ($urandom % 2 == 1) begin
        pulse(bt);
        check("R4 random 25th", bt, 1);
      end
    end
    check("R6 no sleep on normal phases", n_sleep, 0);

    a = W'($urandom);
    b2 = ~a;
    deliver(a);
    deliver(b2);
    read_bits(0, W, b2, "R9 overwrite unread", e);
    pulse(bt);

    a = 24'h12_3456;
    b2 = 24'hED_CBA9;
    deliver(a);
    read_bits(0, 5, a, "R10 head of read", e);
    deliver(b2);
    read_bits(5, W, a, "R10 tail unchanged", e);
    pulse(bt);
    check("R10 release", bt, 1);

    c0 = n_cal;
    s0 = n_sleep;
    deliver(24'h00_0F0F);
    read_bits(0, W, 24'h00_0F0F, "R5 read before cal", e);
    pulse(bt);
    pulse(bt);
    idle(2);
    check("R5 cal strobe", n_cal - c0, 1);
    check("R5 line high after cal", rdy_dout, 1);
    check("R5 no sleep", n_sleep - s0, 0);
    idle(10);
    check("R5 stays high", rdy_dout, 1);
    deliver(24'h55_AA55);
    check("R5 result after cal", rdy_dout, 0);

    s0 = n_sleep;
    w0 = n_wake;
    c0 = n_cal;
    read_bits(0, 3, 24'h55_AA55, "R6 partial read", e);
    @(negedge clk);
    sclk = 1'b1;
    idle(HOLD + 10);
    check("R6 sleep strobe", n_sleep - s0, 1);
    check("R6 line high in sleep", rdy_dout, 1);
    deliver(24'h00_0000);
    idle(2);
    check("R7 result ignored in sleep", rdy_dout, 1);
    sclk = 1'b0;
    idle(6);
    check("R7 wake strobe", n_wake - w0, 1);
    check("R7 no cal on plain wake", n_cal - c0, 0);
    check("R7 line high after wake", rdy_dout, 1);

    a = W'($urandom);
    deliver(a);
    read_bits(0, W, a, "R8 read before hold", e);
    pulse(bt);
    s0 = n_sleep;
    w0 = n_wake;
    c0 = n_cal;
    @(negedge clk);
    sclk = 1'b1;
    idle(HOLD + 10);
    check("R8 sleep from 26th", n_sleep - s0, 1);
    check("R8 no cal at entry", n_cal - c0, 0);
    sclk = 1'b0;
    idle(6);
    check("R8 wake strobe", n_wake - w0, 1);
    check("R8 cal on wake", n_cal - c0, 1);
    check("R8 line high", rdy_dout, 1);

    deliver(24'hC0_FFEE);
    read_bits(0, W, 24'hC0_FFEE, "R11 read after wake", e);
    deliver(24'h0B_ADF0);
    check("R11 accepted after 24 bits", rdy_dout, 0);
    read_bits(0, W, 24'h0B_ADF0, "R11 new word", e);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule